// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Read-During-Write Policy

This block models a single-port synchronous memory with a fixed 16-bit word. On each rising clock edge it samples an address, a write enable and a data word. A read, or the write side effect on the output, becomes visible on the data output in the cycle after that edge. The output never follows the address combinationally.

A parameter sets what the output shows in a cycle that writes. The transparent policy shows the word being written. The old-data policy shows the word the cell held before the write. The hold policy leaves the output at its last read value. A processor built around this memory uses the policy to decide whether a read-modify-write sequence on one cell sees its own store in the next cycle.

Top module: `sync_ram_rdw`

## Requirements
- R1: While rst_n is low, dout is 0.
- R2: On an edge where wr_en is 0, dout takes the word stored at the address sampled at that edge. It is visible from that edge until the next one.
- R3: With RDW_MODE = 0 (transparent), an edge with wr_en = 1 loads dout with wr_data. This holds for every write in a back-to-back series to the same address.
- R4: With RDW_MODE = 1 (old data), an edge with wr_en = 1 loads dout with the word held at the address before the write. The new word is then stored.
- R5: With RDW_MODE = 2 (hold), dout keeps its previous value across an edge with wr_en = 1.
- R6: An edge with wr_en = 0 leaves the contents unchanged, whatever is on wr_data.
- R7: An edge with wr_en = 1 stores wr_data at the sampled address. A later read of that address returns it, in every mode.
- R8: RDW_MODE accepts only 0, 1 and 2. Any other value stops elaboration with an error.
- R9: A write to one address does not disturb the word at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| wr_en | input | 1 | Write strobe for this edge |
| addr | input | ADDR_W | Word address, sampled at the edge |
| wr_data | input | DATA_W (16) | Word to store |
| dout | output | DATA_W (16) | Registered read data |

## Verification
The bench builds three copies with a 16-word array, one for each policy, and drives all three with the same stimulus. Full sweeps write and then read every address with two different patterns. These sweeps separate a correct address decode from aliasing, and show that writes leave other cells alone. Writing over known contents separates the three write policies: new word, old word and held value each differ from the other two. Read cycles that carry changing wr_data show that a disabled write neither stores the data nor reflects it on the output. Back-to-back writes to one cell, and a long mixed run driven by a pseudo-random sequence, test the policies when writes and reads follow one another directly.

// File: rtl/sync_ram_rdw_pkg.sv
package sync_ram_rdw_pkg;

  typedef enum logic [1:0] {
    RDW_NEW  = 2'd0,
    RDW_OLD  = 2'd1,
    RDW_KEEP = 2'd2
  } rdw_policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic memWrite;      // store the input word this edge
    logic outLoad;       // update the output register this edge
    logic outFromInput;  // output register takes the input word, not the array
  } rdw_strobe_t;

endpackage

// File: rtl/sync_ram_rdw_ctrl.sv
module sync_ram_rdw_ctrl
  import sync_ram_rdw_pkg::*;
#(
  parameter int RDW_MODE = 0
) (
  input  logic        wrEn,
  output rdw_strobe_t strobe
);

  localparam rdw_policy_e Policy = rdw_policy_e'(RDW_MODE[1:0]);

  always_comb begin
    strobe = '0;
    strobe.memWrite = wrEn;
    if (!wrEn) begin
      strobe.outLoad = 1'b1;
    end else begin
      case (Policy)
        RDW_NEW: begin
          strobe.outLoad      = 1'b1;
          strobe.outFromInput = 1'b1;
        end
        RDW_OLD:  strobe.outLoad = 1'b1;
        default:  strobe.outLoad = 1'b0;
      endcase
    end
  end

  // R6: the array is never written without the write strobe
  always_comb begin
    assert_no_write_when_idle_R6: assert (wrEn || !strobe.memWrite);
  end

endmodule

// File: rtl/sync_ram_rdw_dp.sv
module sync_ram_rdw_dp
  import sync_ram_rdw_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int RDW_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rdw_strobe_t       strobe,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dout
);

  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] store [Depth];
  logic [DATA_W-1:0] cellWord;
  logic [DATA_W-1:0] outNext;

  assign cellWord = store[addr];
  assign outNext  = strobe.outFromInput ? wrData : cellWord;

  always_ff @(posedge clk) begin
    if (strobe.memWrite) store[addr] <= wrData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              dout <= '0;
    else if (strobe.outLoad) dout <= outNext;
  end

  assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> dout == $past(cellWord));

  assert_write_shows_new_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (RDW_MODE == 0 && wrEn) |=> dout == $past(wrData));

  assert_write_shows_old_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (RDW_MODE == 1 && wrEn) |=> dout == $past(cellWord));

  assert_write_holds_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (RDW_MODE == 2 && wrEn) |=> $stable(dout));

endmodule

// File: rtl/sync_ram_rdw.sv
module sync_ram_rdw
  import sync_ram_rdw_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 16,
  parameter int RDW_MODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] dout
);

  // R8: only the three defined policies elaborate
  if (RDW_MODE < 0 || RDW_MODE > 2) begin : g_badMode
    $error("sync_ram_rdw: RDW_MODE must be 0, 1 or 2");
  end

  rdw_strobe_t strobe;

  sync_ram_rdw_ctrl #(.RDW_MODE(RDW_MODE)) u_ctrl (
    .wrEn   (wr_en),
    .strobe (strobe)
  );

  sync_ram_rdw_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .RDW_MODE (RDW_MODE)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .wrEn   (wr_en),
    .addr   (addr),
    .wrData (wr_data),
    .dout   (dout)
  );

endmodule

// File: tb/sync_ram_rdw_bench.sv
module sync_ram_rdw_bench;

  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] doutNew, doutOld, doutKeep;

  always #4 clk = ~clk;  // 125 MHz

  sync_ram_rdw #(.ADDR_W(AW), .DATA_W(DW), .RDW_MODE(0)) u_sync_ram_rdw (
    .clk(clk), .rst_n(rst_n), .wr_en(wrEn), .addr(addr), .wr_data(wrData), .dout(doutNew));
  sync_ram_rdw #(.ADDR_W(AW), .DATA_W(DW), .RDW_MODE(1)) u_sync_ram_rdw_old (
    .clk(clk), .rst_n(rst_n), .wr_en(wrEn), .addr(addr), .wr_data(wrData), .dout(doutOld));
  sync_ram_rdw #(.ADDR_W(AW), .DATA_W(DW), .RDW_MODE(2)) u_sync_ram_rdw_keep (
    .clk(clk), .rst_n(rst_n), .wr_en(wrEn), .addr(addr), .wr_data(wrData), .dout(doutKeep));

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];
  logic [DW-1:0] expNew = '0, expOld = '0, expKeep = '0;
  bit            oldKnown = 1'b1;

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; leaves at the following negedge
  task automatic step(bit we, logic [AW-1:0] a, logic [DW-1:0] d, string rdTag);
    wrEn = we; addr = a; wrData = d;
    @(posedge clk);
    if (we) begin
      expNew   = d;
      oldKnown = known[a];
      expOld   = model[a];
      model[a] = d;
      known[a] = 1'b1;
    end else begin
      expNew = model[a]; expOld = model[a]; expKeep = model[a];
      oldKnown = 1'b1;
    end
    @(negedge clk);
    if (we) begin
      check("R3", "write shows new", doutNew, expNew);
      if (oldKnown) check("R4", "write shows old", doutOld, expOld);
      check("R5", "write holds out", doutKeep, expKeep);
    end else begin
      check(rdTag, "read new-mode", doutNew, expNew);
      check(rdTag, "read old-mode", doutOld, expOld);
      check(rdTag, "read keep-mode", doutKeep, expKeep);
    end
  endtask

  function automatic logic [DW-1:0] patA(int i);
    return DW'(i * 16'h1111) ^ 16'hA5C3;
  endfunction

  function automatic logic [DW-1:0] patB(int i);
    return DW'((i + 3) * 16'h0F1D) ^ 16'h5A3C;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin : stim
    logic [15:0] lfsr;
    for (int i = 0; i < DEPTH; i++) begin model[i] = '0; known[i] = 1'b0; end
    repeat (3) @(negedge clk);
    check("R1", "reset new-mode", doutNew, '0);
    check("R1", "reset old-mode", doutOld, '0);
    check("R1", "reset keep-mode", doutKeep, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < DEPTH; i++) step(1'b1, AW'(i), patA(i), "R7");
    for (int i = 0; i < DEPTH; i++) step(1'b0, AW'(i), 16'h0, "R9");
    for (int i = DEPTH - 1; i >= 0; i--) step(1'b1, AW'(i), patB(i), "R7");
    for (int i = 0; i < DEPTH; i++) step(1'b0, AW'(i), 16'h0, "R7");

    // disabled writes with live data: contents and outputs must ignore it
    for (int i = 0; i < DEPTH; i++) step(1'b0, AW'(i), ~patB(i), "R6");
    for (int i = 0; i < DEPTH; i++) step(1'b0, AW'(i), 16'hFFFF, "R6");

    // back-to-back writes to one cell (R3 echo each cycle, R4 chain of old values)
    step(1'b1, AW'(5), 16'h1234, "R3");
    step(1'b1, AW'(5), 16'hBEEF, "R3");
    step(1'b1, AW'(5), 16'h0001, "R3");
    step(1'b0, AW'(5), 16'h0, "R7");
    step(1'b0, AW'(4), 16'h0, "R9");
    step(1'b0, AW'(6), 16'h0, "R9");

    // mixed pseudo-random traffic
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], AW'(lfsr[7:4]), lfsr ^ 16'h3C96, "R2");
    end

    // reset clears the outputs again
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "re-reset new-mode", doutNew, '0);
    check("R1", "re-reset old-mode", doutOld, '0);
    check("R1", "re-reset keep-mode", doutKeep, '0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule